// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit gathers the interrupt-worthy events of a UART into one interrupt line for the system interrupt controller. Event pulses from the FIFOs, receiver, transmitter and modem logic set bits in a sticky event register. Software clears those bits one at a time by writing ones to them. A separate mask register decides which events may raise the interrupt. Software changes the mask only through two write-only ports: one sets mask bits and the other clears them. The mask itself can be read but not written.

A second, read-only register shows the live levels of the FIFOs and the activity of the line. This register has its own bit layout, which is not the layout of the event register. Writes to it change nothing. Reads return data in the same cycle. Writes take effect at the next clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on bit n of `evt_in` (n in 0..13) sets bit n of the event register (address 3). The bit stays set after the pulse ends, until software clears it.
- R2: A write to address 3 clears every event bit whose data bit is 1. Event bits whose data bit is 0 keep their value.
- R3: If a source pulse and a clear write hit the same event bit in the same cycle, the bit ends up set. Other bits named in that write are still cleared.
- R4: A write to address 0 sets the mask bits whose data bit is 1. A write to address 1 clears them. The mask reads back at address 2. Writes to address 2 are ignored.
- R5: `irq` is registered. It is 1 exactly one clock after a cycle in which some bit is set in both the event register and the mask. It falls one clock after that overlap ends.
- R6: A read of address 4 returns live status. Bit 14 is `line_lvl[4]`, bit 13 is `line_lvl[3]`, bit 12 is `line_lvl[2]`, bit 11 is `line_lvl[1]` and bit 10 is `line_lvl[0]`. Bits 9..5 read 0. Bits 4..0 are `fifo_lvl[4:0]`.
- R7: Writes to address 4 change neither the event register nor the mask. Bit 14 of the event register and bit 14 of the mask always read 0.
- R8: While `rst_n` is low at a clock edge, that edge clears the event register, the mask and `irq`.
- R9: Reads of addresses 0 and 1, which are write-only, return 0. Reads of addresses 5 to 7, which are unmapped, also return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write address |
| wr_data | input | 15 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 15 | Read data, combinational |
| evt_in | input | 14 | Event pulses, bit n maps to event bit n |
| fifo_lvl | input | 5 | FIFO levels: TX full, TX empty, RX full, RX empty, RX trigger |
| line_lvl | input | 5 | TX nearly full, TX trigger, flow delay, TX active, RX active |
| irq | output | 1 | Interrupt to the system controller |

## Verification
The bench targets the case where a source pulse and a clear write land in the same cycle. A design that gives the clear priority would lose that event. The bench also writes zeros to the clear address and writes to the read-only addresses. A design that decoded these writes loosely would erase events or change the mask. The bench counts the cycles until `irq` rises and falls, to catch an output that is combinational or one stage too slow. It reads the status register with distinct level patterns, so that a swapped field or an unzeroed reserved bit shows up. It also writes the reserved bit 14 and checks that it stays 0.

// File: rtl/uart_irq_pkg.sv
// Package: widths, reserved-bit mask and register addresses shared by the
// interrupt unit. Assumes a 15-bit register map with bit 14 reserved.
package uart_irq_pkg;
    localparam int REG_W     = 15;
    localparam int ADDR_W    = 3;
    localparam int EVT_SRC_W = REG_W - 1;
    localparam int LVL_W     = 5;
    localparam logic [REG_W-1:0] EVT_VALID = {1'b0, {EVT_SRC_W{1'b1}}};

    typedef enum logic [ADDR_W-1:0] {
        A_MASK_SET = 3'd0,
        A_MASK_CLR = 3'd1,
        A_MASK_RD  = 3'd2,
        A_EVENT    = 3'd3,
        A_STATUS   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/uart_irq_event_reg.sv
// Sticky event register. Source pulses set bits and clear strobes reset them.
// A set beats a clear on the same bit. Bits outside VALID never set.
// Assumes set_i and clr_i are already qualified for this cycle.
module uart_irq_event_reg #(
    parameter int W = 15,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] evt_q
);
    logic [W-1:0] set_v;
    logic         armed_q;

    assign set_v = set_i & VALID;

    // Update the event bits: keep, clear, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= ((evt_q & ~clr_i) | set_v) & VALID;
    end

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1: an uncleared set bit stays set
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((evt_q & $past(evt_q & ~clr_i)) == $past(evt_q & ~clr_i)));
    // R3: a source pulse always lands, even against a clear
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((evt_q & $past(set_v)) == $past(set_v)));
    // R7: reserved bits never read as 1
    assert_rsvd_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q & ~VALID) == '0);
endmodule

// File: rtl/uart_irq_mask_reg.sv
// Mask register with separate set and clear strobes. A clear beats a set.
// Bits outside VALID never set. Assumes the strobes are already qualified.
module uart_irq_mask_reg #(
    parameter int W = 15,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] dis_i,
    output logic [W-1:0] mask_q
);
    logic armed_q;

    // Apply the set and clear strobes to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | en_i) & ~dis_i & VALID;
    end

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R4: an enabled bit that was not also disabled reads back set
    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((mask_q & $past(en_i & ~dis_i & VALID)) == $past(en_i & ~dis_i & VALID)));
    // R4: a disabled bit reads back clear
    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((mask_q & $past(dis_i)) == '0));
    // R7: reserved mask bits stay 0
    assert_rsvd_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~VALID) == '0);
endmodule

// File: rtl/uart_irq_rdmux.sv
// Read multiplexer. Builds the raw status word from the level inputs and picks
// a register by address. Write-only and unmapped addresses read 0.
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W,
    parameter int LW = LVL_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  mask_i,
    input  logic [W-1:0]  evt_i,
    input  logic [LW-1:0] fifo_i,
    input  logic [LW-1:0] line_i,
    output logic [W-1:0]  data_o
);
    localparam int RSV_W = W - 2*LW;

    logic [W-1:0] status;

    // Raw status: line levels on top, reserved zeros, FIFO levels at the bottom.
    generate
        if (RSV_W > 0) begin : g_rsv
            assign status = {line_i, {RSV_W{1'b0}}, fifo_i};
        end else begin : g_norsv
            assign status = {line_i, fifo_i};
        end
    endgenerate

    // Pick the register that the read address names.
    always_comb begin
        case (addr_i)
            A_MASK_RD: data_o = mask_i;
            A_EVENT:   data_o = evt_i;
            A_STATUS:  data_o = status;
            default:   data_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// UART interrupt status and mask unit (top). It decodes writes to the
// enable, disable and event-clear ports, and drops writes to read-only
// addresses. It drives a registered interrupt from the AND of events and mask.
// Assumes a single-cycle write strobe and a combinational read path.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W,
    parameter int SW = EVT_SRC_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic [SW-1:0] evt_in,
    input  logic [LW-1:0] fifo_lvl,
    input  logic [LW-1:0] line_lvl,
    output logic          irq
);
    localparam int RSV_LO = LW;
    localparam int RSV_HI = W - LW - 1;

    logic [W-1:0] set_vec, clr_vec, en_vec, dis_vec;
    logic [W-1:0] evt_q, mask_q;
    logic         armed_q;

    // Route each write to the port its address names.
    always_comb begin
        set_vec = W'(evt_in);
        clr_vec = '0;
        en_vec  = '0;
        dis_vec = '0;
        if (wr_en) begin
            case (wr_addr)
                A_EVENT:    clr_vec = wr_data;
                A_MASK_SET: en_vec  = wr_data;
                A_MASK_CLR: dis_vec = wr_data;
                default:    ;
            endcase
        end
    end

    uart_irq_event_reg #(.W(W), .VALID(EVT_VALID)) i_evt (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .evt_q(evt_q)
    );

    uart_irq_mask_reg #(.W(W), .VALID(EVT_VALID)) i_mask (
        .clk(clk), .rst_n(rst_n), .en_i(en_vec), .dis_i(dis_vec), .mask_q(mask_q)
    );

    uart_irq_rdmux #(.W(W), .AW(AW), .LW(LW)) i_rd (
        .addr_i(rd_addr), .mask_i(mask_q), .evt_i(evt_q),
        .fifo_i(fifo_lvl), .line_i(line_lvl), .data_o(rd_data)
    );

    // Register the interrupt from the masked event bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(evt_q & mask_q);
    end

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R5: no overlap last cycle means no interrupt now
    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past((evt_q & mask_q) == '0)) |-> !irq);
    // R5: an overlap last cycle means interrupt now
    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past((evt_q & mask_q) != '0)) |-> irq);
    // R6: reserved status bits read 0
    assert_status_rsv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_STATUS) |-> (rd_data[RSV_HI:RSV_LO] == '0));
    // R7: a write to the status address leaves the mask unchanged
    assert_status_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wr_en && wr_addr == A_STATUS)) |-> (mask_q == $past(mask_q)));
endmodule

// File: tb/test_uart_irq_ctrl.sv
// Bench for uart_irq_ctrl. It walks a vector table and then runs directed
// tests for reset, same-cycle set and clear, interrupt timing and raw status.
module test_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [14:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [14:0] rd_data;
    logic [13:0] evt_in = '0;
    logic [4:0]  fifo_lvl = '0;
    logic [4:0]  line_lvl = '0;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in),
        .fifo_lvl(fifo_lvl), .line_lvl(line_lvl), .irq(irq)
    );

    // Entry: op[23:22] (0 write, 1 event pulse, 2 read check), addr[21:19],
    // data or expected value [18:4], requirement number [3:0].
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 3'd0, 15'h7FFF, 4'd4},  // R4 enable all, bit 14 reserved (R7)
        {2'd2, 3'd2, 15'h3FFF, 4'd4},
        {2'd0, 3'd1, 15'h00F0, 4'd4},  // R4 disable
        {2'd2, 3'd2, 15'h3F0F, 4'd4},
        {2'd0, 3'd2, 15'h0000, 4'd4},  // R4 write to mask readback ignored
        {2'd2, 3'd2, 15'h3F0F, 4'd4},
        {2'd1, 3'd0, 15'h0005, 4'd1},  // R1 events set
        {2'd2, 3'd3, 15'h0005, 4'd1},
        {2'd0, 3'd3, 15'h0001, 4'd2},  // R2 write one clears
        {2'd2, 3'd3, 15'h0004, 4'd2},
        {2'd0, 3'd3, 15'h0000, 4'd2},  // R2 write zero keeps
        {2'd2, 3'd3, 15'h0004, 4'd2},
        {2'd1, 3'd0, 15'h2000, 4'd1},  // R1 top event bit
        {2'd2, 3'd3, 15'h2004, 4'd1},
        {2'd0, 3'd4, 15'h7FFF, 4'd7},  // R7 write to status ignored
        {2'd2, 3'd3, 15'h2004, 4'd7},
        {2'd2, 3'd2, 15'h3F0F, 4'd7},
        {2'd2, 3'd0, 15'h0000, 4'd9},  // R9 write-only ports read 0
        {2'd2, 3'd1, 15'h0000, 4'd9},
        {2'd2, 3'd7, 15'h0000, 4'd9}   // R9 unmapped
    };

    task automatic do_write(input logic [2:0] a, input logic [14:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_pulse(input logic [13:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [14:0] exp, input string tag);
        rd_addr = a;
        #1;
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_run++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 state after reset
        chk_reg(3'd2, 15'h0000, "R8");
        chk_reg(3'd3, 15'h0000, "R8");
        chk_irq(1'b0, "R8");

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][23:22])
                2'd0:    do_write(VEC[i][21:19], VEC[i][18:4]);
                2'd1:    do_pulse(VEC[i][17:4]);
                default: chk_reg(VEC[i][21:19], VEC[i][18:4], $sformatf("R%0d", VEC[i][3:0]));
            endcase
        end

        // R3 a set and a clear on the same bit: the set wins, other clears apply
        do_write(3'd3, 15'h7FFF);
        do_pulse(14'h0020);
        @(negedge clk);
        evt_in = 14'h0008; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 15'h0028;
        @(negedge clk);
        evt_in = '0; wr_en = 1'b0;
        chk_reg(3'd3, 15'h0008, "R3");

        // R5 interrupt timing
        do_write(3'd3, 15'h7FFF);
        do_write(3'd1, 15'h7FFF);
        do_write(3'd0, 15'h0002);
        @(negedge clk);
        chk_irq(1'b0, "R5");
        do_pulse(14'h0020);          // masked event
        @(negedge clk);
        @(negedge clk);
        chk_irq(1'b0, "R5");
        do_pulse(14'h0002);          // event bit now set, irq one clock later
        chk_irq(1'b0, "R5");
        @(negedge clk);
        chk_irq(1'b1, "R5");
        do_write(3'd1, 15'h0002);    // mask cleared, irq falls one clock later
        chk_irq(1'b1, "R5");
        @(negedge clk);
        chk_irq(1'b0, "R5");
        do_write(3'd0, 15'h0002);
        @(negedge clk);
        chk_irq(1'b1, "R5");
        do_write(3'd3, 15'h0002);    // event cleared
        @(negedge clk);
        chk_irq(1'b0, "R5");

        // R6 live raw status with two patterns
        fifo_lvl = 5'h15; line_lvl = 5'h0A;
        chk_reg(3'd4, 15'h2815, "R6");
        fifo_lvl = 5'h0E; line_lvl = 5'h11;
        chk_reg(3'd4, 15'h440E, "R6");

        // R8 reset in mid-run
        do_write(3'd0, 15'h3FFF);
        do_pulse(14'h3FFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_reg(3'd2, 15'h0000, "R8");
        chk_reg(3'd3, 15'h0000, "R8");
        chk_irq(1'b0, "R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule